// File: doc/BRIEF.md
# Thermal Threshold Interrupt Unit

This block watches an 8-bit temperature code and raises interrupts when the code crosses programmable trip points. Each of up to four levels has a rising trip code and a falling trip code. A level's rise event fires on the sample that lifts the code from below its rising trip code to at or above it. A level's fall event fires on the sample that brings the code from above its falling trip code to at or below it. Events latch into a status word. The single interrupt line is the OR of the latched events that software has enabled.

Software drives the unit through a 32-bit register port with byte offsets. A control word starts and stops the comparison core and also holds analog tuning fields, which are only stored. Samples normally come from a sensor strobe. An emulation word can substitute a programmed code, taken on an internal timer, for testing the thermal response without heat. The most recently accepted code can be read back. Latched events are cleared by writing ones.

Top module: `thermal_irq_unit`

## Requirements
- R1: After reset every register reads zero except the ready word at 0x28, which always reads 1, and `irq` is low.
- R2: Writable words sit at 0x20 (control, writable mask 0x1F70FF03), 0x50 (rising trip codes, level i in bits [8i+7:8i]), 0x54 (falling trip codes, same layout), 0x70 (enable, writable mask 0x11111111) and 0x80 (emulation, all 32 bits), and each reads back what was written under its mask; unmapped offsets read zero.
- R3: The core runs only while control bits [1:0] equal 3. In any other state no sample is accepted, so the current code and the status word gain nothing.
- R4: While running with emulation off, a high `sns_valid` accepts `sns_code` at that clock edge, and the code reads at 0x40 from the next cycle.
- R5: On an accepted sample, status bit 4i (level i rise) sets when the previous code was below rising trip code i and the new code is at or above it. The previous code is zero after reset.
- R6: On an accepted sample, status bit 16+4i (level i fall) sets when the previous code was above falling trip code i and the new code is at or below it.
- R7: A trip code byte of zero disables that comparison.
- R8: Status bits set whatever the enables are. `irq` is high exactly when the status word ANDed with the enable word (0x70) is nonzero, in the same cycle as the register change.
- R9: Writing to 0x78 clears every status bit written as one, for example 0x111 for rise levels 0 to 2. An event arriving at the same edge wins over the clear, and 0x78 reads zero.
- R10: With emulation bit 0 set and the core running, emulation bits [15:8] are accepted as the code once every (bits [31:16] + 1) cycles, counted from the cycle after enabling, and `sns_valid` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| sns_valid | input | 1 | Sensor sample strobe |
| sns_code | input | 8 | Sensor temperature code |
| irq | output | 1 | Level interrupt |

## Verification
A register write, an accepted sample and the status update it causes all land at the same clock edge. `reg_rdata` and `irq` show the result combinationally from the cycle after that edge, so every result is due exactly one cycle after its stimulus. The bench keeps a behavioural reference model that updates at each rising edge from the inputs driven before it. Two nanoseconds after the edge it drives the next inputs, and one nanosecond later it compares the read data for the addressed word and `irq` against the model. Emulated samples are due every interval-plus-one cycles, and the model counts those cycles itself.

// File: rtl/thermal_pkg.sv
`timescale 1ns/1ps
package thermal_pkg;

    localparam int CODE_W  = 8;
    localparam int MAX_LVL = 4;

    localparam logic [7:0] OFS_CTRL   = 8'h20;
    localparam logic [7:0] OFS_READY  = 8'h28;
    localparam logic [7:0] OFS_CURT   = 8'h40;
    localparam logic [7:0] OFS_RISE   = 8'h50;
    localparam logic [7:0] OFS_FALL   = 8'h54;
    localparam logic [7:0] OFS_ENABLE = 8'h70;
    localparam logic [7:0] OFS_STATUS = 8'h74;
    localparam logic [7:0] OFS_CLEAR  = 8'h78;
    localparam logic [7:0] OFS_EMUL   = 8'h80;

    localparam logic [31:0] CTRL_WMASK = 32'h1F70_FF03;
    localparam logic [31:0] EVT_MASK   = 32'h1111_1111;

    typedef enum logic [1:0] {
        CORE_OFF0 = 2'd0,
        CORE_OFF1 = 2'd1,
        CORE_STOP = 2'd2,
        CORE_RUN  = 2'd3
    } core_state_e;

    typedef struct packed {
        logic [15:0]       interval;
        logic [CODE_W-1:0] code;
        logic [6:0]        spare;
        logic              en;
    } emul_cfg_t;

    typedef struct packed {
        logic              take;
        logic [CODE_W-1:0] code;
    } sample_t;

    function automatic int unsigned rise_pos(input int unsigned lvl);
        return 4 * lvl;
    endfunction

    function automatic int unsigned fall_pos(input int unsigned lvl);
        return 16 + 4 * lvl;
    endfunction

    function automatic logic [CODE_W-1:0] trip_byte(input logic [31:0] word,
                                                    input int unsigned lvl);
        return word[CODE_W*lvl +: CODE_W];
    endfunction

endpackage

// File: rtl/thermal_sample_src.sv
`timescale 1ns/1ps
module thermal_sample_src
    import thermal_pkg::*;
#(
    parameter int TIMER_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               running,
    input  logic               emul_en,
    input  logic [CODE_W-1:0]  emul_code,
    input  logic [TIMER_W-1:0] emul_interval,
    input  logic               sns_valid,
    input  logic [CODE_W-1:0]  sns_code,
    output sample_t            smp
);

    logic [TIMER_W-1:0] tick_q;
    logic               expire;

    assign expire = (tick_q == emul_interval);

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q <= '0;
        end else if (running && emul_en) begin
            tick_q <= expire ? '0 : tick_q + 1'b1;
        end else begin
            tick_q <= '0;
        end
    end

    always_comb begin
        smp.code = emul_en ? emul_code : sns_code;
        smp.take = running && (emul_en ? expire : sns_valid);
    end

endmodule

// File: rtl/thermal_level_cmp.sv
`timescale 1ns/1ps
module thermal_level_cmp
    import thermal_pkg::*;
#(
    parameter int NUM_LEVELS = 4
) (
    input  sample_t                 smp,
    input  logic [CODE_W-1:0]       prev_code,
    input  logic [31:0]             rise_trips,
    input  logic [31:0]             fall_trips,
    output logic [NUM_LEVELS-1:0]   rise_hit,
    output logic [NUM_LEVELS-1:0]   fall_hit
);

    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
        logic [CODE_W-1:0] up_trip;
        logic [CODE_W-1:0] dn_trip;
        assign up_trip = trip_byte(rise_trips, g);
        assign dn_trip = trip_byte(fall_trips, g);

        assign rise_hit[g] = smp.take && (up_trip != '0)
                           && (prev_code < up_trip) && (smp.code >= up_trip);
        assign fall_hit[g] = smp.take && (dn_trip != '0)
                           && (prev_code > dn_trip) && (smp.code <= dn_trip);
    end

endmodule

// File: rtl/thermal_evt_status.sv
`timescale 1ns/1ps
module thermal_evt_status
    import thermal_pkg::*;
#(
    parameter int NUM_LEVELS = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_LEVELS-1:0] rise_hit,
    input  logic [NUM_LEVELS-1:0] fall_hit,
    input  logic                  clr_we,
    input  logic [31:0]           clr_data,
    input  logic [31:0]           enable,
    output logic [31:0]           status,
    output logic                  irq
);

    logic [31:0] set_vec;
    logic [31:0] clr_vec;

    always_comb begin
        set_vec = '0;
        for (int unsigned i = 0; i < NUM_LEVELS; i++) begin
            set_vec[rise_pos(i)] = rise_hit[i];
            set_vec[fall_pos(i)] = fall_hit[i];
        end
        clr_vec = clr_we ? (clr_data & EVT_MASK) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
        end else begin
            status <= (status & ~clr_vec) | set_vec;
        end
    end

    assign irq = |(status & enable);

endmodule

// File: rtl/thermal_irq_unit.sv
`timescale 1ns/1ps
module thermal_irq_unit
    import thermal_pkg::*;
#(
    parameter int NUM_LEVELS = 4,
    parameter int TIMER_W    = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        sns_valid,
    input  logic [7:0]  sns_code,
    output logic        irq
);

    localparam int LVL_USED = (NUM_LEVELS > MAX_LVL) ? MAX_LVL : NUM_LEVELS;

    logic [31:0]       ctrl_q;
    logic [31:0]       rise_q;
    logic [31:0]       fall_q;
    logic [31:0]       en_q;
    emul_cfg_t         emul_q;
    logic [CODE_W-1:0] cur_code_q;
    logic [31:0]       stat_q;

    logic              core_run;
    logic              emul_en;
    sample_t           smp_sel;
    logic              smp_take;
    logic [LVL_USED-1:0] rise_hit;
    logic [LVL_USED-1:0] fall_hit;
    logic              clr_we;

    assign core_run = (core_state_e'(ctrl_q[1:0]) == CORE_RUN);
    assign emul_en  = emul_q.en;
    assign clr_we   = reg_we && (reg_addr == OFS_CLEAR);
    assign smp_take = smp_sel.take;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            rise_q <= '0;
            fall_q <= '0;
            en_q   <= '0;
            emul_q <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                OFS_CTRL:   ctrl_q <= reg_wdata & CTRL_WMASK;
                OFS_RISE:   rise_q <= reg_wdata;
                OFS_FALL:   fall_q <= reg_wdata;
                OFS_ENABLE: en_q   <= reg_wdata & EVT_MASK;
                OFS_EMUL:   emul_q <= emul_cfg_t'(reg_wdata);
                default:    ;
            endcase
        end
    end

    thermal_sample_src #(
        .TIMER_W (TIMER_W)
    ) u_src (
        .clk           (clk),
        .rst           (rst),
        .running       (core_run),
        .emul_en       (emul_en),
        .emul_code     (emul_q.code),
        .emul_interval (emul_q.interval[TIMER_W-1:0]),
        .sns_valid     (sns_valid),
        .sns_code      (sns_code),
        .smp           (smp_sel)
    );

    thermal_level_cmp #(
        .NUM_LEVELS (LVL_USED)
    ) u_cmp (
        .smp        (smp_sel),
        .prev_code  (cur_code_q),
        .rise_trips (rise_q),
        .fall_trips (fall_q),
        .rise_hit   (rise_hit),
        .fall_hit   (fall_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_code_q <= '0;
        end else if (smp_take) begin
            cur_code_q <= smp_sel.code;
        end
    end

    thermal_evt_status #(
        .NUM_LEVELS (LVL_USED)
    ) u_stat (
        .clk      (clk),
        .rst      (rst),
        .rise_hit (rise_hit),
        .fall_hit (fall_hit),
        .clr_we   (clr_we),
        .clr_data (reg_wdata),
        .enable   (en_q),
        .status   (stat_q),
        .irq      (irq)
    );

    always_comb begin
        case (reg_addr)
            OFS_CTRL:   reg_rdata = ctrl_q;
            OFS_READY:  reg_rdata = 32'h1;
            OFS_CURT:   reg_rdata = {{(32-CODE_W){1'b0}}, cur_code_q};
            OFS_RISE:   reg_rdata = rise_q;
            OFS_FALL:   reg_rdata = fall_q;
            OFS_ENABLE: reg_rdata = en_q;
            OFS_STATUS: reg_rdata = stat_q;
            OFS_EMUL:   reg_rdata = emul_q;
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/thermal_irq_unit_chk.sv
`timescale 1ns/1ps
module thermal_irq_unit_chk
    import thermal_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        running,
    input logic        take,
    input logic        emul_en,
    input logic [7:0]  cur_q,
    input logic [31:0] stat_q,
    input logic [31:0] en_q,
    input logic        irq,
    input logic        reg_we,
    input logic [7:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata
);

    // R3: a stopped core keeps the current code
    a_r3_stopped_code: assert property (@(posedge clk) disable iff (rst)
        !running |=> $stable(cur_q));

    // R3: a stopped core latches no new event
    a_r3_stopped_status: assert property (@(posedge clk) disable iff (rst)
        !running |=> ((stat_q & ~$past(stat_q)) == 32'h0));

    // R5 / R6: new status bits only arrive with an accepted sample
    a_r5_events_need_sample: assert property (@(posedge clk) disable iff (rst)
        !take |=> ((stat_q & ~$past(stat_q)) == 32'h0));

    // R9: write-one-to-clear removes the written bits
    a_r9_clear_bits: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == OFS_CLEAR && !take)
        |=> ((stat_q & $past(reg_wdata)) == 32'h0));

    // R9: the clear word reads zero
    a_r9_clear_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == OFS_CLEAR) |-> (reg_rdata == 32'h0));

    // R8: no enabled bit, no interrupt
    a_r8_irq_masked: assert property (@(posedge clk) disable iff (rst)
        (en_q == 32'h0) |-> !irq);

    // R1: the ready word always reads one
    a_r1_ready_word: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == OFS_READY) |-> (reg_rdata == 32'h1));

    // R10: under emulation the code only moves on a timer tick
    a_r10_strobe_ignored: assert property (@(posedge clk) disable iff (rst)
        (emul_en && running && !take) |=> $stable(cur_q));

endmodule

bind thermal_irq_unit thermal_irq_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .running   (core_run),
    .take      (smp_take),
    .emul_en   (emul_en),
    .cur_q     (cur_code_q),
    .stat_q    (stat_q),
    .en_q      (en_q),
    .irq       (irq),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata)
);

// File: tb/test_thermal_irq_unit.sv
`timescale 1ns/1ps
module test_thermal_irq_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_we;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        sns_valid;
    logic [7:0]  sns_code;
    logic        irq;

    always #5 clk = ~clk;

    thermal_irq_unit i_thermal_irq_unit (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .sns_valid (sns_valid),
        .sns_code  (sns_code),
        .irq       (irq)
    );

    int    checks = 0;
    int    errors = 0;
    string phase  = "R1";
    bit    done   = 1'b0;

    // behavioural reference model
    bit [31:0] m_ctrl, m_rise, m_fall, m_en, m_stat, m_emul;
    bit [7:0]  m_cur;
    bit [15:0] m_tmr;

    always @(posedge clk) begin
        if (rst) begin
            m_ctrl = 0; m_rise = 0; m_fall = 0; m_en = 0;
            m_stat = 0; m_emul = 0; m_cur = 0; m_tmr = 0;
        end else begin
            bit        run;
            bit        take;
            bit [7:0]  c;
            bit [31:0] setv;
            run  = (m_ctrl[1:0] == 2'b11);
            take = 0;
            c    = sns_code;
            if (run && m_emul[0]) begin
                c = m_emul[15:8];
                if (m_tmr == m_emul[31:16]) begin
                    take  = 1;
                    m_tmr = 0;
                end else begin
                    m_tmr = m_tmr + 1;
                end
            end else begin
                m_tmr = 0;
                take  = run && sns_valid;
            end
            setv = 0;
            if (take) begin
                for (int i = 0; i < 4; i++) begin
                    int r;
                    int f;
                    r = m_rise[8*i +: 8];
                    f = m_fall[8*i +: 8];
                    if (r != 0 && int'(m_cur) < r && int'(c) >= r) setv[4*i] = 1;
                    if (f != 0 && int'(m_cur) > f && int'(c) <= f) setv[16+4*i] = 1;
                end
                m_cur = c;
            end
            if (reg_we && reg_addr == 8'h78) m_stat = m_stat & ~reg_wdata;
            m_stat = m_stat | setv;
            if (reg_we) begin
                case (reg_addr)
                    8'h20: m_ctrl = reg_wdata & 32'h1F70FF03;
                    8'h50: m_rise = reg_wdata;
                    8'h54: m_fall = reg_wdata;
                    8'h70: m_en   = reg_wdata & 32'h11111111;
                    8'h80: m_emul = reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic bit [31:0] model_read(input bit [7:0] a);
        case (a)
            8'h20: return m_ctrl;
            8'h28: return 32'h1;
            8'h40: return {24'h0, m_cur};
            8'h50: return m_rise;
            8'h54: return m_fall;
            8'h70: return m_en;
            8'h74: return m_stat;
            8'h80: return m_emul;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", phase, what, got, exp);
        end
    endtask

    task automatic step(input bit we, input bit [7:0] a, input bit [31:0] d,
                        input bit sv, input bit [7:0] code);
        reg_we    = we;
        reg_addr  = a;
        reg_wdata = d;
        sns_valid = sv;
        sns_code  = code;
        #1;
        check($sformatf("read 0x%h", a), reg_rdata, model_read(a));
        check("irq", {31'h0, irq}, {31'h0, |(m_stat & m_en)});
        @(posedge clk);
        #2;
    endtask

    task automatic rd(input bit [7:0] a);
        step(0, a, 0, 0, 0);
    endtask

    task automatic wr(input bit [7:0] a, input bit [31:0] d);
        step(1, a, d, 0, 0);
    endtask

    task automatic smp(input bit [7:0] code);
        step(0, 8'h74, 0, 1, code);
        rd(8'h40);
    endtask

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not end, got running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1; reg_we = 0; reg_addr = 0; reg_wdata = 0; sns_valid = 0; sns_code = 0;
        repeat (3) @(posedge clk);
        #2 rst = 0;

        phase = "R1";
        foreach (rd_list[k]) rd(rd_list[k]);

        phase = "R2";
        wr(8'h20, 32'hFFFF_FFFE);
        rd(8'h20);
        wr(8'h50, 32'h0050_4030);
        wr(8'h54, 32'h0045_3525);
        wr(8'h70, 32'hFFFF_FFFF);
        rd(8'h50); rd(8'h54); rd(8'h70); rd(8'h3C);

        phase = "R3";
        smp(8'h60);
        rd(8'h74);

        phase = "R4";
        wr(8'h20, 32'h0000_0003);
        smp(8'h20);

        phase = "R5";
        smp(8'h35);
        rd(8'h74);
        smp(8'h55);
        rd(8'h74);

        phase = "R6";
        smp(8'h30);
        rd(8'h74);

        phase = "R9";
        wr(8'h78, 32'h0000_0111);
        rd(8'h74);
        wr(8'h78, 32'h0011_1000);
        rd(8'h74);
        rd(8'h78);
        step(1, 8'h78, 32'hFFFF_FFFF, 1, 8'h50);
        rd(8'h74);

        phase = "R8";
        wr(8'h70, 32'h0);
        rd(8'h74);
        wr(8'h70, 32'h0000_0100);
        rd(8'h74);
        wr(8'h78, 32'hFFFF_FFFF);
        rd(8'h74);

        phase = "R7";
        smp(8'hFF);
        smp(8'h00);
        rd(8'h74);
        wr(8'h78, 32'hFFFF_FFFF);

        phase = "R10";
        wr(8'h70, 32'h1111_1111);
        wr(8'h80, {16'd3, 8'h70, 7'h0, 1'b1});
        for (int n = 0; n < 16; n++) step(0, (n % 2) ? 8'h40 : 8'h74, 0, 1, 8'h10);
        wr(8'h80, {16'd0, 8'h20, 7'h0, 1'b1});
        for (int n = 0; n < 4; n++) rd(8'h74);
        wr(8'h80, 32'h0);
        smp(8'h44);

        phase = "R5 R6 mix";
        for (int n = 0; n < 3000; n++) begin
            bit [7:0]  addrs [7];
            bit [31:0] d;
            addrs = '{8'h20, 8'h50, 8'h54, 8'h70, 8'h78, 8'h80, 8'h74};
            d = $urandom;
            if ($urandom_range(0, 9) < 3) begin
                bit [7:0] a;
                a = addrs[$urandom_range(0, 6)];
                if (a == 8'h20) d = ($urandom_range(0, 7) == 0) ? 32'h2 : 32'h3;
                if (a == 8'h80) d = {12'h0, 4'(d[19:16]), d[15:8], 7'h0, d[0] & d[1]};
                step(1, a, d, $urandom_range(0, 1), 8'($urandom));
            end else begin
                step(0, ($urandom_range(0, 1) == 0) ? 8'h74 : 8'h40, 0,
                     $urandom_range(0, 1), 8'($urandom));
            end
        end

        done = 1;
        summary();
        $finish;
    end

    bit [7:0] rd_list [10] = '{8'h20, 8'h28, 8'h40, 8'h50, 8'h54,
                               8'h70, 8'h74, 8'h78, 8'h80, 8'h00};

endmodule